// File: doc/BRIEF.md
# Power Stage Fault Supervisor

This block is the digital protection and status supervisor of a step-down point-of-load converter. It receives comparator results that are already digital: overcurrent, overvoltage, undervoltage, an over-temperature "hot" flag and a separate "cooled down" flag. It also receives a ramping flag, an output-in-window flag and the sampled level of a shared fault line. From these it produces the converter run command, the pull-down enable of an open-drain power-good pin and the pull-down enable of an open-drain fault line.

A fault flag must stay high for a set number of clock cycles before it counts. A qualified overvoltage is latched. The converter then stays stopped until the enable input goes low. The other three faults stop the converter for a fixed hiccup period and then allow a restart. An over-temperature stop also waits for the cooled-down flag before it restarts.

While any fault stop is active, the block pulls the shared fault line low. Any low on that line from outside gates the run command off. Several converters can be wired together through this line. The qualification time (nominally 6 µs) and the hiccup period (nominally 130 ms) are set by parameters in clock cycles.

Top module: `pol_fault_supervisor`

## Requirements
- R1: While reset is asserted, and until the two-stage reset synchronizer releases, the block holds `run_o`=0, `pg_oe_o`=1 and `fbus_oe_o`=0.
- R2: With no fault present, `run_o` goes to 1 on the first clock edge that sees `en_i`=1 after the block leaves the stopped state. `run_o` goes to 0 on the first edge that sees `en_i`=0.
- R3: A fault flag that is high for fewer than QUAL_CYC consecutive clock edges has no effect. A flag that stays high takes `run_o` to 0 on edge QUAL_CYC+1, counted from the first edge that sees it high.
- R4: A qualified overvoltage stops the converter and sets `fbus_oe_o`=1. Both stay that way after the flag clears, however long that lasts. They hold until `en_i` is seen low. After that, `en_i`=1 restarts the converter one edge later.
- R5: A qualified overcurrent or undervoltage stops the converter and sets `fbus_oe_o`=1 for exactly HICCUP_CYC clock edges. After that, `run_o` returns to 1 and `fbus_oe_o` to 0.
- R6: After an over-temperature stop, the converter does not restart until `ot_cool_i` is seen high, even if the hiccup period has expired and `ot_hot_i` has cleared. Once `ot_cool_i`=1, `run_o` returns on the second edge.
- R7: An overvoltage that qualifies during a hiccup stop takes priority and is latched. The converter stays off with `fbus_oe_o`=1 after every fault flag has cleared, until `en_i` is cycled.
- R8: A low on `fbus_pin_i` while running forces `run_o` to 0 at once, without a clock edge, and does not set `fbus_oe_o`. `run_o` returns as soon as the line is high again.
- R9: `pg_oe_o`=0 (power-good released) only while `run_o`=1, `ramp_i`=0 and the qualified window status is good. `ramp_i`=1 asserts `pg_oe_o` at once. A change of `inwin_i` reaches the qualified status only after it has held for QUAL_CYC consecutive edges, in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable; a low level clears a latched overvoltage |
| oc_i | input | 1 | Overcurrent comparator result |
| ov_i | input | 1 | Overvoltage comparator result |
| uv_i | input | 1 | Undervoltage comparator result |
| ot_hot_i | input | 1 | Temperature above the shutdown threshold |
| ot_cool_i | input | 1 | Temperature below the restart threshold |
| ramp_i | input | 1 | Output voltage is ramping up or down |
| inwin_i | input | 1 | Output voltage is inside the power-good window |
| fbus_pin_i | input | 1 | Sampled level of the shared fault line |
| run_o | output | 1 | Converter run command |
| pg_oe_o | output | 1 | Pull power-good low when 1 |
| fbus_oe_o | output | 1 | Pull the shared fault line low when 1 |

## Verification
Random fault pulses shorter than the qualification window, on every fault input, check that glitches never stop the converter. Directed pulses of exactly QUAL_CYC and QUAL_CYC+1 edges pin down the boundary. Random window dropouts of lengths on both sides of QUAL_CYC separate a filtered glitch from a real loss of power-good. Directed sequences cover the following cases, telling apart latching, timed, temperature-gated and externally forced stops:
- each fault class alone;
- overvoltage arriving during a hiccup;
- the cool flag arriving after the hiccup has expired;
- an external low on the fault line.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int unsigned NF   = 4;
  localparam int unsigned F_OC = 0;
  localparam int unsigned F_OV = 1;
  localparam int unsigned F_UV = 2;
  localparam int unsigned F_OT = 3;

  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_RUN = 2'd1,
    ST_HIC = 2'd2,
    ST_OVL = 2'd3
  } sup_st_e;
endpackage

// File: rtl/pss_rst_sync.sv
module pss_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_s_n <= meta_q;
    end
  end
endmodule

// File: rtl/pss_qual.sv
module pss_qual #(
  parameter int unsigned CYC = 300,
  parameter bit          SYM = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic q_o
);
  localparam int unsigned CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          q_d;
  logic          rel_fast;

  generate
    if (SYM) begin : g_sym
      assign rel_fast = 1'b0;
    end else begin : g_fast
      assign rel_fast = ~raw_i;
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    q_d   = q_o;
    if (raw_i == q_o) begin
      cnt_d = '0;
    end else if (rel_fast) begin
      q_d   = 1'b0;
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      q_d   = raw_i;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      q_o   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      q_o   <= q_d;
    end
  end

  AST_QUAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_o) |-> $past(raw_i)); // R3

  generate
    if (!SYM) begin : g_chk
      AST_FAST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_i |=> !q_o); // R3
    end
  endgenerate
endmodule

// File: rtl/pss_seq.sv
module pss_seq
  import pss_pkg::*;
#(
  parameter int unsigned HICCUP_CYC = 6500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [NF-1:0] flt_i,
  input  logic          ot_cool_i,
  output logic          run_st_o,
  output logic          fdrv_o
);
  localparam int unsigned HW = (HICCUP_CYC > 1) ? $clog2(HICCUP_CYC) : 1;
  localparam logic [HW-1:0] HLAST = HW'(HICCUP_CYC - 1);

  sup_st_e       st_q, st_d;
  logic [HW-1:0] hcnt_q, hcnt_d;
  logic          otf_q, otf_d;
  logic          retry_flt;

  assign retry_flt = flt_i[F_OC] | flt_i[F_UV] | flt_i[F_OT];

  always_comb begin
    st_d   = st_q;
    hcnt_d = hcnt_q;
    if (flt_i[F_OT])    otf_d = 1'b1;
    else if (ot_cool_i) otf_d = 1'b0;
    else                otf_d = otf_q;
    unique case (st_q)
      ST_OFF: if (en_i && !otf_q) st_d = ST_RUN;
      ST_RUN: begin
        if (!en_i)              st_d = ST_OFF;
        else if (flt_i[F_OV])   st_d = ST_OVL;
        else if (retry_flt) begin
          st_d   = ST_HIC;
          hcnt_d = '0;
        end
      end
      ST_HIC: begin
        if (!en_i)              st_d = ST_OFF;
        else if (flt_i[F_OV])   st_d = ST_OVL;
        else if (hcnt_q == HLAST) begin
          if (!otf_q)           st_d = ST_RUN;
        end else begin
          hcnt_d = hcnt_q + 1'b1;
        end
      end
      ST_OVL: if (!en_i) st_d = ST_OFF;
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      hcnt_q <= '0;
      otf_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      hcnt_q <= hcnt_d;
      otf_q  <= otf_d;
    end
  end

  assign run_st_o = (st_q == ST_RUN);
  assign fdrv_o   = (st_q == ST_HIC) || (st_q == ST_OVL);

  AST_OV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OVL && en_i) |=> (st_q == ST_OVL)); // R4

  AST_HIC_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_HIC && st_q == ST_RUN) |-> ($past(hcnt_q) == HLAST)); // R5

  AST_OT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_HIC && st_q == ST_RUN) |-> !$past(otf_q)); // R6
endmodule

// File: rtl/pol_fault_supervisor.sv
module pol_fault_supervisor
  import pss_pkg::*;
#(
  parameter int unsigned QUAL_CYC   = 300,
  parameter int unsigned HICCUP_CYC = 6500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic oc_i,
  input  logic ov_i,
  input  logic uv_i,
  input  logic ot_hot_i,
  input  logic ot_cool_i,
  input  logic ramp_i,
  input  logic inwin_i,
  input  logic fbus_pin_i,
  output logic run_o,
  output logic pg_oe_o,
  output logic fbus_oe_o
);
  logic          rst_s_n;
  logic [NF-1:0] raw_vec, flt_q;
  logic          win_q;
  logic          run_st;

  pss_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  assign raw_vec[F_OC] = oc_i;
  assign raw_vec[F_OV] = ov_i;
  assign raw_vec[F_UV] = uv_i;
  assign raw_vec[F_OT] = ot_hot_i;

  for (genvar g = 0; g < NF; g++) begin : g_flt
    pss_qual #(.CYC(QUAL_CYC), .SYM(1'b0)) u_q (
      .clk(clk), .rst_n(rst_s_n), .raw_i(raw_vec[g]), .q_o(flt_q[g]));
  end

  pss_qual #(.CYC(QUAL_CYC), .SYM(1'b1)) u_win (
    .clk(clk), .rst_n(rst_s_n), .raw_i(inwin_i), .q_o(win_q));

  pss_seq #(.HICCUP_CYC(HICCUP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .en_i(en_i), .flt_i(flt_q),
    .ot_cool_i(ot_cool_i), .run_st_o(run_st), .fdrv_o(fbus_oe_o));

  assign run_o   = run_st & fbus_pin_i;
  assign pg_oe_o = ~(run_o & ~ramp_i & win_q);

  AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_s_n)
    !en_i |=> !run_o); // R2

  AST_PG_RUN: assert property (@(posedge clk) disable iff (!rst_s_n)
    !pg_oe_o |-> (run_o && !ramp_i)); // R9

  AST_FDRV_STOP: assert property (@(posedge clk) disable iff (!rst_s_n)
    fbus_oe_o |-> !run_o); // R5
endmodule

// File: tb/pol_fault_supervisor_test.sv
module pol_fault_supervisor_test;
  localparam int unsigned Q   = 6;
  localparam int unsigned HIC = 40;

  logic clk = 1'b0;
  logic rst_n, en, oc, ov, uv, hot, cool, ramp, inwin, ext_pull;
  logic fbus_pin, run, pg_oe, fbus_oe;
  int   nchk = 0;
  int   nerr = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  assign fbus_pin = ~(fbus_oe | ext_pull);

  pol_fault_supervisor #(.QUAL_CYC(Q), .HICCUP_CYC(HIC)) uut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .oc_i(oc), .ov_i(ov), .uv_i(uv),
    .ot_hot_i(hot), .ot_cool_i(cool), .ramp_i(ramp), .inwin_i(inwin),
    .fbus_pin_i(fbus_pin), .run_o(run), .pg_oe_o(pg_oe), .fbus_oe_o(fbus_oe));

  function automatic logic exp_pg_lost(int unsigned len);
    return (len >= Q);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(input string rq, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", rq, act, exp, $time);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; en = 1'b1; oc = 0; ov = 0; uv = 0; hot = 0; cool = 1;
    ramp = 0; inwin = 1; ext_pull = 0;
    tick(3);
    chk("R1 run in reset", run, 1'b0);
    chk("R1 pg in reset", pg_oe, 1'b1);
    chk("R1 fbus in reset", fbus_oe, 1'b0);
    rst_n = 1'b1;
    tick(2);
    chk("R1 run during sync", run, 1'b0);
    tick(1);
    chk("R2 start", run, 1'b1);
    tick(Q + 2);
    chk("R9 pg good", pg_oe, 1'b0);

    en = 0; tick(1);
    chk("R2 stop", run, 1'b0);
    chk("R9 pg when stopped", pg_oe, 1'b1);
    en = 1; tick(1);
    chk("R2 restart", run, 1'b1);

    // R3 random glitches shorter than the window
    for (int i = 0; i < 30; i++) begin
      int unsigned len = 1 + ($urandom % (Q - 1));
      int unsigned which = $urandom % 4;
      case (which)
        0: oc = 1; 1: ov = 1; 2: uv = 1; default: hot = 1;
      endcase
      tick(len);
      oc = 0; ov = 0; uv = 0; hot = 0;
      tick(1 + ($urandom % 3));
      chk("R3 glitch ignored", run, 1'b1);
      chk("R3 glitch no fbus", fbus_oe, 1'b0);
    end

    // R9 random window dropouts
    for (int i = 0; i < 20; i++) begin
      int unsigned len = 1 + ($urandom % (2 * Q));
      inwin = 0;
      tick(len);
      chk("R9 window filter", pg_oe, exp_pg_lost(len));
      inwin = 1;
      tick(Q + 2);
      chk("R9 window back", pg_oe, 1'b0);
    end

    // R9 exact window edges and ramp
    inwin = 0; tick(Q - 1);
    chk("R9 window drop early", pg_oe, 1'b0);
    tick(1);
    chk("R9 window drop", pg_oe, 1'b1);
    inwin = 1; tick(Q - 1);
    chk("R9 window rise early", pg_oe, 1'b1);
    tick(1);
    chk("R9 window rise", pg_oe, 1'b0);
    ramp = 1; #1;
    chk("R9 ramp", pg_oe, 1'b1);
    ramp = 0; #1;
    chk("R9 ramp end", pg_oe, 1'b0);
    tick(1);

    // R3 boundary, R5 hiccup on overcurrent
    oc = 1; tick(Q);
    chk("R3 oc before trip", run, 1'b1);
    tick(1);
    chk("R3 oc trip", run, 1'b0);
    chk("R5 oc fbus", fbus_oe, 1'b1);
    chk("R9 pg in fault", pg_oe, 1'b1);
    oc = 0; tick(HIC - 1);
    chk("R5 hiccup hold", run, 1'b0);
    chk("R5 hiccup fbus hold", fbus_oe, 1'b1);
    tick(1);
    chk("R5 hiccup end", run, 1'b1);
    chk("R5 fbus release", fbus_oe, 1'b0);

    // R5 undervoltage
    uv = 1; tick(Q + 1);
    chk("R5 uv trip", run, 1'b0);
    uv = 0; tick(HIC - 1);
    chk("R5 uv hold", run, 1'b0);
    tick(1);
    chk("R5 uv restart", run, 1'b1);

    // R6 temperature hysteresis
    cool = 0; hot = 1; tick(Q + 1);
    chk("R6 ot trip", run, 1'b0);
    hot = 0; tick(HIC + 5);
    chk("R6 waits for cool", run, 1'b0);
    chk("R6 fbus held", fbus_oe, 1'b1);
    cool = 1; tick(1);
    chk("R6 cool first edge", run, 1'b0);
    tick(1);
    chk("R6 cool restart", run, 1'b1);

    // R4 overvoltage latch
    ov = 1; tick(Q + 1);
    chk("R4 ov trip", run, 1'b0);
    chk("R4 ov fbus", fbus_oe, 1'b1);
    ov = 0; tick(HIC + 10);
    chk("R4 ov latched", run, 1'b0);
    chk("R4 ov fbus latched", fbus_oe, 1'b1);
    en = 0; tick(1);
    chk("R4 en clears fbus", fbus_oe, 1'b0);
    en = 1; tick(1);
    chk("R4 restart", run, 1'b1);

    // R7 overvoltage during hiccup
    oc = 1; tick(Q + 1);
    chk("R7 oc trip", run, 1'b0);
    ov = 1; tick(Q + 1);
    oc = 0; ov = 0; tick(HIC + 5);
    chk("R7 latched over hiccup", run, 1'b0);
    chk("R7 fbus latched", fbus_oe, 1'b1);
    en = 0; tick(1);
    en = 1; tick(1);
    chk("R7 restart after en", run, 1'b1);

    // R8 external fault line
    ext_pull = 1; #1;
    chk("R8 ext stop", run, 1'b0);
    chk("R8 no own drive", fbus_oe, 1'b0);
    tick(3);
    chk("R8 ext hold", run, 1'b0);
    ext_pull = 0; #1;
    chk("R8 ext release", run, 1'b1);
    tick(1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule